// File: doc/BRIEF.md
# Cumulative Fault Timer and Protection Sequencer

This block sequences the protection of a half-bridge resonant converter. It takes filtered comparator flags and decides, cycle by cycle, whether the gate drivers may switch. The flags are feedback below its fault level, overload above its first and second thresholds, raw bulk-voltage OK, an external latch request, over-temperature, and supply reset. Its outputs are driver enable, a soft-start discharge request and a frequency-shift request. It also drives the enable of the brown-out hysteresis sink.

At its centre is a saturating up/down counter that stands in for a timer capacitor. Overload charges it quickly. Feedback loss also charges it, but only when the variant-select input enables that. Whenever nothing charges it, the counter drains slowly. Because a fault that clears does not reset it, short repeated faults add up. When the counter reaches its upper mark, the drivers stop and the counter drains. A new start with soft-start is allowed only once the counter falls below its lower mark, so a fault that persists produces hiccup operation. Two separately filtered hard latches override everything until supply reset: the second overload threshold and the latch request. Control pins are plain levels; no stream data flows through the block.

Top module: `fault_timer_seq`

## Requirements
- R1: While the drivers run, each cycle with `olp_lvl1` high adds `TMR_CHG` (default 4) to `timer_lvl`. `fb_low` does the same, but only when `fb_fault_en` is 1. The sum saturates at `TMR_TOP` (default 400).
- R2: In a cycle with no charging cause, `timer_lvl` falls by `TMR_DIS` (default 1) and stops at 0. A fault that clears never resets the counter.
- R3: When `timer_lvl` has reached `TMR_TOP` while running, the next cycle turns `drv_en` off and raises `ss_dis`, and charging stops.
- R4: After a timer stop, `drv_en` stays low until `timer_lvl` is below `TMR_LOW` (default 100). It then returns after `SS_CYC` cycles of soft-start discharge.
- R5: `olp_lvl2` held for `OL2_CYC` consecutive cycles (default 50, 1 us at 50 MHz) sets `latched_off` and turns the drivers off. A shorter pulse has no effect. The latch holds until `vcc_rst` is asserted.
- R6: `latch_req` held for `LREQ_CYC` consecutive cycles (default 250) sets `latched_off` in the same way. A shorter pulse has no effect.
- R7: The bulk-OK decision changes only after `bo_raw` has held its new value for `BO_CYC` cycles (default 1000). `bo_sink_en` is high exactly while the filtered decision is not OK.
- R8: `ss_dis` is high whenever `drv_en` is low. Every start (power-up, hiccup retry, brown-out recovery, over-temperature recovery, unlatch) is preceded by `SS_CYC` cycles with `ss_dis` high.
- R9: With `fb_fault_en` at 0, `fb_low` has no effect on `timer_lvl`.
- R10: `freq_shift` equals `olp_lvl1` in every cycle, whatever the timer or sequencer state.
- R11: If a hard latch and the timer upper mark take effect in the same cycle, the latch wins. The drivers stay off after the counter drains below `TMR_LOW`.
- R12: `vcc_rst` clears the latch, the latch filters and the counter, and forces the drivers off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_rst | input | 1 | Supply below logic-reset level; clears latches |
| fb_low | input | 1 | Feedback below fault level |
| fb_fault_en | input | 1 | Variant select: 1 lets feedback loss charge the timer |
| olp_lvl1 | input | 1 | Overload above first threshold |
| olp_lvl2 | input | 1 | Overload above latch threshold |
| bo_raw | input | 1 | Unfiltered bulk-voltage OK comparator |
| latch_req | input | 1 | External latch request comparator |
| over_temp | input | 1 | Over-temperature flag |
| drv_en | output | 1 | Gate drivers allowed to switch |
| ss_dis | output | 1 | Soft-start network discharge request |
| freq_shift | output | 1 | Overload frequency-shift request |
| bo_sink_en | output | 1 | Brown-out hysteresis sink enable |
| latched_off | output | 1 | Hard latch is set |
| timer_lvl | output | 9 | Fault timer level (TMR_TOP corresponds to the upper mark) |

## Verification
Two functions can meet in one cycle: the timer reaching its upper mark and a hard latch filter expiring. The bench first charges the timer to exactly half of `TMR_TOP`. It then raises `olp_lvl1` and `olp_lvl2` together, so the counter saturates on the same edge that the second-threshold filter completes. The result is judged correct when `latched_off` is set and the drivers never return, even after the counter has drained well below `TMR_LOW`; a hiccup retry at that point would be an error. Only `vcc_rst` then brings the converter back through soft-start.

// File: rtl/ftq_pkg.sv
package ftq_pkg;
  typedef enum logic [2:0] {
    SQ_STOP   = 3'd0,
    SQ_PREP   = 3'd1,
    SQ_RUN    = 3'd2,
    SQ_HICCUP = 3'd3,
    SQ_LATCH  = 3'd4
  } seq_state_t;
endpackage

// File: rtl/ftq_persist_filter.sv
module ftq_persist_filter #(
  parameter int HOLD_CYC = 50,
  parameter bit INIT_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic din,
  output logic dout
);
  localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= INIT_VAL;
    end else if (clr) begin
      cnt_q <= '0;
      out_q <= INIT_VAL;
    end else if (din == out_q) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      out_q <= din;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign dout = out_q;

  // R5 R6 R7: the output only moves toward a value the input was holding
  a_r7_moves_toward_input: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(clr) && out_q != $past(out_q)) |-> $past(din) == out_q);
endmodule

// File: rtl/ftq_fault_timer.sv
module ftq_fault_timer #(
  parameter int TMR_TOP = 400,
  parameter int TMR_CHG = 4,
  parameter int TMR_DIS = 1,
  localparam int TW = $clog2(TMR_TOP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          charge,
  output logic [TW-1:0] level
);
  localparam logic [TW-1:0] TOPV = TW'(TMR_TOP);
  localparam logic [TW-1:0] CHGV = TW'(TMR_CHG);
  localparam logic [TW-1:0] DISV = TW'(TMR_DIS);

  logic [TW-1:0] lvl_q, lvl_d;

  always_comb begin
    if (charge) begin
      lvl_d = (lvl_q > TOPV - CHGV) ? TOPV : lvl_q + CHGV;
    end else begin
      lvl_d = (lvl_q < DISV) ? '0 : lvl_q - DISV;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   lvl_q <= '0;
    else if (clr) lvl_q <= '0;
    else          lvl_q <= lvl_d;
  end

  assign level = lvl_q;

  a_r1_never_above_top: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= TOPV);

  a_r2_slow_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !charge && lvl_q >= DISV) |=> lvl_q == $past(lvl_q) - DISV);

  a_r1_charge_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && charge && lvl_q < TOPV) |=> lvl_q > $past(lvl_q));
endmodule

// File: rtl/ftq_sequencer.sv
module ftq_sequencer
  import ftq_pkg::*;
#(
  parameter int TMR_TOP = 400,
  parameter int TMR_LOW = 100,
  parameter int SS_CYC  = 16,
  localparam int TW = $clog2(TMR_TOP + 1),
  localparam int SW = (SS_CYC > 1) ? $clog2(SS_CYC) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run_ok,
  input  logic          latch_now,
  input  logic [TW-1:0] tmr_lvl,
  output logic          running,
  output logic          ss_dis,
  output logic          latched
);
  localparam logic [TW-1:0] TOPV = TW'(TMR_TOP);
  localparam logic [TW-1:0] LOWV = TW'(TMR_LOW);
  localparam logic [SW-1:0] SS_LAST = SW'(SS_CYC - 1);

  seq_state_t    st_q, st_d;
  logic [SW-1:0] ss_cnt_q;
  logic          lat_q;

  always_comb begin
    st_d = st_q;
    if (lat_q || latch_now) begin
      st_d = SQ_LATCH;
    end else begin
      unique case (st_q)
        SQ_STOP:   if (run_ok) st_d = SQ_PREP;
        SQ_PREP:   if (!run_ok) st_d = SQ_STOP;
                   else if (ss_cnt_q == SS_LAST) st_d = SQ_RUN;
        SQ_RUN:    if (!run_ok) st_d = SQ_STOP;
                   else if (tmr_lvl >= TOPV) st_d = SQ_HICCUP;
        SQ_HICCUP: if (tmr_lvl < LOWV) st_d = run_ok ? SQ_PREP : SQ_STOP;
        SQ_LATCH:  st_d = SQ_LATCH;
        default:   st_d = SQ_STOP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= SQ_STOP;
      ss_cnt_q <= '0;
      lat_q    <= 1'b0;
    end else if (clr) begin
      st_q     <= SQ_STOP;
      ss_cnt_q <= '0;
      lat_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      lat_q    <= lat_q | latch_now;
      ss_cnt_q <= (st_q == SQ_PREP && st_d == SQ_PREP) ? ss_cnt_q + 1'b1 : '0;
    end
  end

  assign running = (st_q == SQ_RUN);
  assign ss_dis  = (st_q != SQ_RUN);
  assign latched = lat_q;

  a_r3_stop_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_RUN && tmr_lvl >= TOPV && !latch_now && !lat_q && !clr && run_ok)
      |=> st_q == SQ_HICCUP);

  a_r4_wait_low_mark: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_HICCUP && tmr_lvl >= LOWV && !clr) |=> st_q != SQ_PREP && st_q != SQ_RUN);

  a_r5_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q && !clr) |=> lat_q && st_q == SQ_LATCH);

  a_r8_prep_before_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> $past(st_q) == SQ_PREP);

  a_r11_latch_keeps_off: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q && !clr) |=> !running);
endmodule

// File: rtl/fault_timer_seq.sv
module fault_timer_seq #(
  parameter int TMR_TOP  = 400,
  parameter int TMR_LOW  = 100,
  parameter int TMR_CHG  = 4,
  parameter int TMR_DIS  = 1,
  parameter int SS_CYC   = 16,
  parameter int OL2_CYC  = 50,
  parameter int LREQ_CYC = 250,
  parameter int BO_CYC   = 1000,
  localparam int TW = $clog2(TMR_TOP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vcc_rst,
  input  logic          fb_low,
  input  logic          fb_fault_en,
  input  logic          olp_lvl1,
  input  logic          olp_lvl2,
  input  logic          bo_raw,
  input  logic          latch_req,
  input  logic          over_temp,
  output logic          drv_en,
  output logic          ss_dis,
  output logic          freq_shift,
  output logic          bo_sink_en,
  output logic          latched_off,
  output logic [TW-1:0] timer_lvl
);
  logic ol2_f, lreq_f, bo_ok_f;
  logic running, charge;

  ftq_persist_filter #(.HOLD_CYC(OL2_CYC), .INIT_VAL(1'b0)) u_ol2_filt (
    .clk(clk), .rst_n(rst_n), .clr(vcc_rst), .din(olp_lvl2), .dout(ol2_f));

  ftq_persist_filter #(.HOLD_CYC(LREQ_CYC), .INIT_VAL(1'b0)) u_lreq_filt (
    .clk(clk), .rst_n(rst_n), .clr(vcc_rst), .din(latch_req), .dout(lreq_f));

  ftq_persist_filter #(.HOLD_CYC(BO_CYC), .INIT_VAL(1'b0)) u_bo_filt (
    .clk(clk), .rst_n(rst_n), .clr(1'b0), .din(bo_raw), .dout(bo_ok_f));

  assign charge = running & (olp_lvl1 | (fb_low & fb_fault_en));

  ftq_fault_timer #(.TMR_TOP(TMR_TOP), .TMR_CHG(TMR_CHG), .TMR_DIS(TMR_DIS)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(vcc_rst), .charge(charge), .level(timer_lvl));

  ftq_sequencer #(.TMR_TOP(TMR_TOP), .TMR_LOW(TMR_LOW), .SS_CYC(SS_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .clr(vcc_rst),
    .run_ok(bo_ok_f & ~over_temp),
    .latch_now(ol2_f | lreq_f),
    .tmr_lvl(timer_lvl),
    .running(running), .ss_dis(ss_dis), .latched(latched_off));

  assign drv_en     = running;
  assign freq_shift = olp_lvl1;
  assign bo_sink_en = ~bo_ok_f;

  a_r8_discharge_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en |-> ss_dis);

  a_r12_supply_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    vcc_rst |=> !latched_off && !drv_en && timer_lvl == '0);
endmodule

// File: tb/test_fault_timer_seq.sv
module test_fault_timer_seq;
  localparam int TOP = 400, LOW = 100, SSC = 16, OL2 = 50, LRQ = 250, BOC = 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vcc_rst = 0, fb_low = 0, fb_fault_en = 0, olp_lvl1 = 0, olp_lvl2 = 0;
  logic bo_raw = 0, latch_req = 0, over_temp = 0;
  logic drv_en, ss_dis, freq_shift, bo_sink_en, latched_off;
  logic [8:0] timer_lvl;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fault_timer_seq i_fault_timer_seq (
    .clk(clk), .rst_n(rst_n), .vcc_rst(vcc_rst), .fb_low(fb_low),
    .fb_fault_en(fb_fault_en), .olp_lvl1(olp_lvl1), .olp_lvl2(olp_lvl2),
    .bo_raw(bo_raw), .latch_req(latch_req), .over_temp(over_temp),
    .drv_en(drv_en), .ss_dis(ss_dis), .freq_shift(freq_shift),
    .bo_sink_en(bo_sink_en), .latched_off(latched_off), .timer_lvl(timer_lvl));

  // table: fb_low, fb_fault_en, olp_lvl1, cycles, expected timer level
  localparam int NV = 7;
  localparam int TV_FB  [NV] = '{1, 1, 0, 0, 0, 0, 0};
  localparam int TV_EN  [NV] = '{0, 1, 0, 0, 0, 0, 0};
  localparam int TV_OL  [NV] = '{0, 0, 0, 1, 0, 1, 0};
  localparam int TV_CYC [NV] = '{10, 10, 15, 25, 5, 10, 60};
  localparam int TV_EXP [NV] = '{0, 40, 25, 125, 120, 160, 100};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    // reset state
    chk(drv_en == 0 && ss_dis == 1, "R8 reset drivers off", drv_en, 0);
    chk(timer_lvl == 0, "R2 reset timer", timer_lvl, 0);
    chk(bo_sink_en == 1 && latched_off == 0, "R7 reset sink on", bo_sink_en, 1);

    bo_raw = 1;
    step(BOC + SSC + 10);
    chk(drv_en == 1 && ss_dis == 0, "R8 power-up start", drv_en, 1);
    chk(bo_sink_en == 0, "R7 sink off once ok", bo_sink_en, 0);

    for (int i = 0; i < NV; i++) begin
      fb_low = TV_FB[i][0]; fb_fault_en = TV_EN[i][0]; olp_lvl1 = TV_OL[i][0];
      @(posedge clk); @(negedge clk);
      chk(freq_shift == olp_lvl1, "R10 freq shift follows", freq_shift, olp_lvl1);
      step(TV_CYC[i] - 1);
      chk(timer_lvl == TV_EXP[i], (i == 0) ? "R9 gated fb" : (i == 2 || i == 4 || i == 6) ? "R2 drain" : "R1 charge",
          timer_lvl, TV_EXP[i]);
      chk(drv_en == 1, "R1 still running", drv_en, 1);
    end
    fb_low = 0; fb_fault_en = 0;

    // hiccup: 100 -> 400 in 75 cycles
    olp_lvl1 = 1;
    step(75);
    chk(timer_lvl == TOP && drv_en == 1, "R1 saturate at top", timer_lvl, TOP);
    olp_lvl1 = 0;
    step(1);
    chk(drv_en == 0 && ss_dis == 1, "R3 stop at top", drv_en, 0);
    step(250);
    chk(drv_en == 0, "R4 wait below low mark", drv_en, 0);
    chk(timer_lvl == 149, "R3 timer drains in hiccup", timer_lvl, 149);
    step(81);
    chk(drv_en == 1 && ss_dis == 0, "R4 hiccup retry", drv_en, 1);

    // brown-out glitch then real drop
    bo_raw = 0; step(BOC / 2); bo_raw = 1; step(2);
    chk(drv_en == 1 && bo_sink_en == 0, "R7 glitch rejected", drv_en, 1);
    bo_raw = 0; step(BOC + 2);
    chk(drv_en == 0 && bo_sink_en == 1 && ss_dis == 1, "R7 brown-out stop", drv_en, 0);
    bo_raw = 1; step(BOC + 2);
    chk(drv_en == 0 && ss_dis == 1, "R8 discharge before bo restart", ss_dis, 1);
    step(SSC + 3);
    chk(drv_en == 1, "R8 bo recovery", drv_en, 1);

    // over-temperature
    over_temp = 1; step(2);
    chk(drv_en == 0 && ss_dis == 1, "R8 otp stop", drv_en, 0);
    over_temp = 0; step(3);
    chk(ss_dis == 1, "R8 discharge before otp restart", ss_dis, 1);
    step(SSC + 3);
    chk(drv_en == 1, "R8 otp recovery", drv_en, 1);

    // second overload threshold
    olp_lvl2 = 1; step(OL2 - 1); olp_lvl2 = 0; step(3);
    chk(latched_off == 0 && drv_en == 1, "R5 short pulse ignored", latched_off, 0);
    olp_lvl2 = 1; step(OL2 + 3); olp_lvl2 = 0;
    chk(latched_off == 1 && drv_en == 0, "R5 latch set", latched_off, 1);
    step(600);
    chk(latched_off == 1 && drv_en == 0, "R5 latch holds", latched_off, 1);
    vcc_rst = 1; step(2);
    chk(latched_off == 0 && drv_en == 0 && timer_lvl == 0, "R12 supply reset", latched_off, 0);
    vcc_rst = 0; step(SSC + 10);
    chk(drv_en == 1, "R12 restart after reset", drv_en, 1);

    // latch request input
    latch_req = 1; step(LRQ - 1); latch_req = 0; step(3);
    chk(latched_off == 0, "R6 short request ignored", latched_off, 0);
    latch_req = 1; step(LRQ + 3); latch_req = 0;
    chk(latched_off == 1 && drv_en == 0, "R6 latch set", latched_off, 1);
    vcc_rst = 1; step(2); vcc_rst = 0; step(SSC + 10);
    chk(drv_en == 1 && timer_lvl == 0, "R12 clean restart", drv_en, 1);

    // coincidence: timer top and latch filter on same edge
    olp_lvl1 = 1; step(50);
    chk(timer_lvl == 200, "R11 preset half", timer_lvl, 200);
    olp_lvl2 = 1; step(OL2);
    chk(timer_lvl == TOP, "R11 top reached", timer_lvl, TOP);
    step(2);
    olp_lvl1 = 0; olp_lvl2 = 0;
    chk(latched_off == 1 && drv_en == 0, "R11 latch wins", latched_off, 1);
    step(TOP);
    chk(timer_lvl == 0 && drv_en == 0, "R11 no hiccup retry", drv_en, 0);
    vcc_rst = 1; step(2); vcc_rst = 0; step(SSC + 10);
    chk(drv_en == 1, "R12 recovery", drv_en, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule